// File: doc/BRIEF.md
# SPI Slave with Length-Framed Acknowledge

This block is a SPI slave that works in clock mode 0. Within a single chip-select window, a master sends a length byte and then that many payload bytes. The slave checks them and answers with one status byte. The check runs one byte at a time as the data arrives, so the answer is already known when the last payload byte has been clocked in. The status byte is placed in the transmit shifter before the master starts that byte. The master may therefore stop SCLK for as long as it likes between the payload and the status byte, with chip select held low.

A frame is valid when the 8-bit wrapping sum of the length byte and every payload byte equals zero. The last payload byte therefore serves as a checksum. A length of zero is always invalid. The SPI pins are sampled through synchronizers in the system-clock domain, which must run at least eight times faster than SCLK. A completed frame is reported by a one-cycle pulse together with a verdict flag.

Top module: `spi_ack_slave`

## Requirements
- R1: Data moves MSB first. MOSI is taken on the rising SCLK edge. MISO changes only after a falling SCLK edge or the falling edge of cs_n, never at any other time.
- R2: The first byte after cs_n falls is the payload count N. N payload bytes follow it, and MISO sends 0x00 during the count byte and all payload bytes.
- R3: The byte that follows the N payload bytes is the status byte. MISO sends 0xA5 during it if the modulo-256 sum of the count byte and all N payload bytes is 0x00, and 0x5A otherwise.
- R4: A count byte of 0x00 makes the very next byte the status byte, and that byte is 0x5A.
- R5: After the eighth rising SCLK edge of the status byte, frame_done goes high for exactly one system clock. At the same time frame_ok becomes 1 if 0xA5 was sent and 0 if 0x5A was sent, and it keeps that value until the next pulse.
- R6: SCLK may stop for any length of time between the last payload bit and the first status bit while cs_n stays low. The status byte is still correct.
- R7: If cs_n rises before the status byte is complete, even in the middle of a byte, the frame is dropped. No frame_done pulse is given, and the next low period of cs_n starts again with a count byte.
- R8: Bytes clocked after the status byte in the same cs_n window are ignored. MISO sends 0xFF during them and no further frame_done pulse is given.
- R9: While reset is held and right after it, miso, frame_done and frame_ok are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Master-to-slave serial data |
| miso | output | 1 | Slave-to-master serial data |
| frame_done | output | 1 | One-cycle pulse when a status byte completes |
| frame_ok | output | 1 | Verdict of the last completed frame (1 = acknowledged) |

## Verification
The bench drives a long SCLK stall before the status byte. A design that loaded the reply lazily, or that lost its bit position during the stall, would send a corrupted or zero status byte. It sends single-byte frames, a frame with a count of zero, and frames whose checksum is off by one. Each of these catches an error in the count of remaining bytes or in the sum by sending the wrong code or sending it one byte early or late. It drops chip select both on a byte boundary and in the middle of a byte, then sends a clean frame. A design that failed to clear its bit counter or frame state would misalign the next count byte, or would pulse for the dropped frame. Trailing bytes after the status byte must read 0xFF and must not pulse. A design that re-armed would produce a second verdict.

// File: rtl/spi_ack_pkg.sv
package spi_ack_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] byte_t;
  typedef enum logic [1:0] {ST_LEN, ST_PAY, ST_STAT, ST_DONE} frame_st_t;

  function automatic byte_t sum8(input byte_t acc, input byte_t val);
    return acc + val;
  endfunction

  function automatic logic frame_good(input byte_t len, input byte_t sum);
    return (len != '0) && (sum == '0);
  endfunction
endpackage

// File: rtl/spi_ack_sync.sv
module spi_ack_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= RST_VAL;
        else        pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_ack_shift.sv
module spi_ack_shift
  import spi_ack_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  cs_s,
  input  logic  mosi_s,
  input  byte_t tx_next,
  output logic  miso,
  output logic  byte_done,
  output byte_t rx_byte,
  output logic  sclk_fall_evt,
  output logic  cs_fall_evt,
  output logic  cs_rise_evt
);
  localparam int BW = $clog2(DW);

  logic          sclk_q, cs_q;
  logic          sclk_rise_evt;
  logic [BW-1:0] bit_cnt;
  byte_t         rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end

  assign cs_fall_evt   = cs_q & ~cs_s;
  assign cs_rise_evt   = ~cs_q & cs_s;
  assign sclk_rise_evt = ~cs_s & sclk_s & ~sclk_q;
  assign sclk_fall_evt = ~cs_s & ~sclk_s & sclk_q;

  assign byte_done = sclk_rise_evt && (bit_cnt == BW'(DW-1));
  assign rx_byte   = {rx_sh[DW-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (cs_s) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (sclk_rise_evt) begin
      rx_sh   <= rx_byte;
      bit_cnt <= (bit_cnt == BW'(DW-1)) ? '0 : bit_cnt + 1'b1;
    end

  // Load the next byte when the previous one has finished; otherwise shift.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 tx_sh <= '0;
    else if (cs_fall_evt)       tx_sh <= tx_next;
    else if (sclk_fall_evt) begin
      if (bit_cnt == '0)        tx_sh <= tx_next;
      else                      tx_sh <= {tx_sh[DW-2:0], 1'b0};
    end

  assign miso = tx_sh[DW-1];
endmodule

// File: rtl/spi_ack_ctrl.sv
module spi_ack_ctrl
  import spi_ack_pkg::*;
#(
  parameter byte_t ACK_CODE  = 8'hA5,
  parameter byte_t NACK_CODE = 8'h5A,
  parameter byte_t FILL_CODE = 8'h00,
  parameter byte_t POST_CODE = 8'hFF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_s,
  input  logic      byte_done,
  input  byte_t     rx_byte,
  output byte_t     tx_next,
  output logic      frame_done,
  output logic      frame_ok,
  output frame_st_t state,
  output byte_t     len_q
);
  byte_t sum_q, remain;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_LEN;
      len_q      <= '0;
      sum_q      <= '0;
      remain     <= '0;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (cs_s) begin
        state <= ST_LEN;
      end else if (byte_done) begin
        case (state)
          ST_LEN: begin
            len_q  <= rx_byte;
            sum_q  <= rx_byte;
            remain <= rx_byte;
            state  <= (rx_byte == '0) ? ST_STAT : ST_PAY;
          end
          ST_PAY: begin
            sum_q  <= sum8(sum_q, rx_byte);
            remain <= remain - 1'b1;
            if (remain == byte_t'(1)) state <= ST_STAT;
          end
          ST_STAT: begin
            frame_done <= 1'b1;
            frame_ok   <= frame_good(len_q, sum_q);
            state      <= ST_DONE;
          end
          default: state <= ST_DONE;
        endcase
      end
    end

  always_comb
    case (state)
      ST_STAT: tx_next = frame_good(len_q, sum_q) ? ACK_CODE : NACK_CODE;
      ST_DONE: tx_next = POST_CODE;
      default: tx_next = FILL_CODE;
    endcase
endmodule

// File: rtl/spi_ack_slave.sv
module spi_ack_slave
  import spi_ack_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter byte_t ACK_CODE    = 8'hA5,
  parameter byte_t NACK_CODE   = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic frame_done,
  output logic frame_ok
);
  logic      sclk_s, cs_s, mosi_s;
  logic      byte_done, sclk_fall_evt, cs_fall_evt, cs_rise_evt;
  byte_t     rx_byte, tx_next, len_q;
  frame_st_t state;

  spi_ack_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk
    (.clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  spi_ack_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs
    (.clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  spi_ack_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi
    (.clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));

  spi_ack_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .mosi_s(mosi_s),
    .tx_next(tx_next), .miso(miso), .byte_done(byte_done), .rx_byte(rx_byte),
    .sclk_fall_evt(sclk_fall_evt), .cs_fall_evt(cs_fall_evt),
    .cs_rise_evt(cs_rise_evt)
  );

  spi_ack_ctrl #(.ACK_CODE(ACK_CODE), .NACK_CODE(NACK_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .byte_done(byte_done),
    .rx_byte(rx_byte), .tx_next(tx_next), .frame_done(frame_done),
    .frame_ok(frame_ok), .state(state), .len_q(len_q)
  );
endmodule

// File: rtl/spi_ack_slave_chk.sv
module spi_ack_slave_chk
  import spi_ack_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_s,
  input logic      miso,
  input logic      byte_done,
  input byte_t     rx_byte,
  input logic      sclk_fall_evt,
  input logic      cs_fall_evt,
  input logic      cs_rise_evt,
  input frame_st_t state,
  input byte_t     len_q,
  input logic      frame_done,
  input logic      frame_ok
);
  a_r1_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall_evt && !cs_fall_evt) |=> $stable(miso));

  a_r4_zero_len_to_status: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == ST_LEN && rx_byte == '0) |=> state == ST_STAT);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r5_ok_needs_length: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_ok) |-> len_q != '0);

  a_r7_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |=> (state == ST_LEN && !frame_done));

  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !cs_s) |=> (state == ST_DONE && !frame_done));
endmodule

bind spi_ack_slave spi_ack_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .miso(miso), .byte_done(byte_done),
  .rx_byte(rx_byte), .sclk_fall_evt(sclk_fall_evt), .cs_fall_evt(cs_fall_evt),
  .cs_rise_evt(cs_rise_evt), .state(state), .len_q(len_q),
  .frame_done(frame_done), .frame_ok(frame_ok)
);

// File: tb/spi_ack_slave_test.sv
`timescale 1ns/1ps
module spi_ack_slave_test;
  localparam int HALF = 8;   // system clocks per SCLK half period
  localparam int NV   = 6;
  localparam int NB   = 5;
  localparam logic [7:0] VEC [NV][NB] = '{
    '{8'd3, 8'h10, 8'h20, 8'hCD, 8'h00},
    '{8'd3, 8'h10, 8'h20, 8'hCE, 8'h00},
    '{8'd1, 8'hFF, 8'h00, 8'h00, 8'h00},
    '{8'd1, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'd4, 8'h01, 8'h02, 8'h03, 8'hF6},
    '{8'd2, 8'h80, 8'h7E, 8'h00, 8'h00}
  };

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, frame_done, frame_ok;
  int checks = 0, fails = 0, pulses = 0;
  logic last_ok = 0;
  bit finished = 0;

  spi_ack_slave uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .frame_done(frame_done), .frame_ok(frame_ok));

  always #2 clk = ~clk;

  always @(posedge clk) if (frame_done) begin
    pulses  <= pulses + 1;
    last_ok <= frame_ok;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      waitc(HALF);
      rx[i] = miso;
      sclk = 1;
      waitc(HALF);
      sclk = 0;
    end
  endtask

  task automatic sel();   cs_n = 0; waitc(HALF); endtask
  task automatic desel(); waitc(HALF); cs_n = 1; waitc(2 * HALF); endtask

  function automatic logic [7:0] expect_status(input logic [7:0] b [NB]);
    logic [7:0] s = 0;
    for (int k = 0; k <= int'(b[0]); k++) s = s + b[k];
    return (b[0] != 0 && s == 0) ? 8'hA5 : 8'h5A;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, st;
    logic [7:0] fb [NB];
    int p0, fill_bad;
    waitc(3);
    check("R9 miso in reset", miso, 0);
    check("R9 frame_done in reset", frame_done, 0);
    rst_n = 1;
    waitc(4);
    check("R9 frame_ok after reset", frame_ok, 0);

    // Table-driven frames: R2 fill, R3 status, R5 pulse and verdict
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < NB; k++) fb[k] = VEC[v][k];
      st = expect_status(fb);
      p0 = pulses; fill_bad = 0;
      sel();
      for (int k = 0; k <= int'(fb[0]); k++) begin
        xfer(fb[k], rx);
        if (rx != 8'h00) fill_bad++;
      end
      if (v == 4) waitc(3000);   // R6 long clock stall before status
      xfer(8'h00, rx);
      waitc(4);
      check("R2 fill bytes zero", fill_bad, 0);
      check(v == 4 ? "R6 status after stall" : "R3 status code", rx, st);
      check("R5 one pulse", pulses - p0, 1);
      check("R5 verdict", last_ok, st == 8'hA5);
      desel();
    end

    // R4 zero length
    p0 = pulses;
    sel(); xfer(8'h00, rx); xfer(8'h00, st); waitc(4);
    check("R4 zero-length status", st, 8'h5A);
    check("R4 zero-length verdict", last_ok, 0);
    // R8 trailing bytes
    xfer(8'h33, rx); check("R8 trailing fill", rx, 8'hFF);
    xfer(8'hA5, rx); check("R8 trailing fill 2", rx, 8'hFF);
    waitc(4);
    check("R8 no extra pulse", pulses - p0, 1);
    desel();

    // R7 abort on byte boundary
    p0 = pulses;
    sel(); xfer(8'd3, rx); xfer(8'h11, rx); desel();
    check("R7 no pulse on abort", pulses - p0, 0);
    // R7 abort mid byte
    sel();
    for (int i = 0; i < 3; i++) begin
      mosi = 1; waitc(HALF); sclk = 1; waitc(HALF); sclk = 0;
    end
    desel();
    check("R7 no pulse mid-byte abort", pulses - p0, 0);
    sel(); xfer(8'd1, rx); xfer(8'hFF, rx); xfer(8'h00, st); waitc(4);
    check("R7 clean frame after abort", st, 8'hA5);
    check("R7 pulse after abort", pulses - p0, 1);
    desel();

    // R1 MSB first: a status byte of 0x5A must arrive bit-for-bit
    sel(); xfer(8'd1, rx); xfer(8'h01, rx); xfer(8'h00, st); waitc(4);
    check("R1 MSB-first status", st, 8'h5A);
    desel();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule